// File: doc/BRIEF.md
# Modulo-8 Symbol Scrambler

This block whitens a stream of 3-bit symbols, each a value from 0 to 7, by adding a key value to every symbol modulo 8. The sum is not an XOR. Two key sources are available. In data mode the key comes from a 12-bit pseudo-random shift-register generator. The generator starts from a fixed seed, advances eight steps for every symbol and returns to the seed at a fixed symbol period. In preamble mode the key comes from a fixed 32-entry sequence that repeats.

Symbols arrive with a valid strobe and a mode select, at a rate of up to one per clock. Each scrambled symbol appears one clock later with its own valid strobe. A synchronous restart input returns the generator, the data period counter and the preamble position to their starting values. An upstream framer uses it at the start of a burst.

Top module: `sym_scrambler`

## Requirements
- R1: After reset, out_valid is 0, the generator holds 0xBAD, and both the data symbol count and the preamble position are 0.
- R2: In data mode (preamble_mode = 0), out_sym = (in_sym + k) mod 8. The key k is the low 3 bits of the generator, read before the generator advances for that symbol. The first data symbol after reset therefore uses k = 5.
- R3: After each data symbol the generator advances exactly 8 steps. In one step the register shifts left by one and bit 0 takes 0. If the old bit 11 was 1, the result is XORed with 0x052. The register is kept to 12 bits.
- R4: Data symbols 1 to 160 after a seed load use the sequence that starts from the seed. Symbol 161 uses the seed again, and so on every 160 data symbols.
- R5: In preamble mode (preamble_mode = 1), out_sym = (in_sym + P[i mod 32]) mod 8. Here i counts preamble symbols, and P is 7,4,3,0,5,1,5,0,2,2,1,1,5,7,4,3,5,0,2,6,2,1,6,2,0,0,5,0,5,2,6,6.
- R6: Preamble symbols leave the generator and the data symbol count unchanged. Data symbols leave the preamble position unchanged.
- R7: When restart is 1, the generator reloads 0xBAD and both the count and the position clear. A symbol presented in the same cycle is scrambled from this fresh state.
- R8: out_valid equals in_valid delayed by exactly one clock. Symbols keep their order and none is dropped.
- R9: A cycle with in_valid = 0 (and restart = 0) changes no state. out_sym holds its previous value in that cycle, whatever in_sym and preamble_mode carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Reload seed, clear count and preamble position |
| in_valid | input | 1 | Input symbol strobe |
| preamble_mode | input | 1 | 1 selects the fixed sequence, 0 selects the generator |
| in_sym | input | 3 | Input symbol |
| out_valid | output | 1 | Output symbol strobe |
| out_sym | output | 3 | Scrambled symbol |

## Verification
Zero-valued data symbols expose the raw key, so a wrong seed or a wrong step shows up directly. A rising 0..7 sweep over more than two 160-symbol periods separates a true modulo-8 sum from an XOR and checks every reload point. Preamble runs of more than 32 symbols, placed between stretches of data, show the index wrapping and show that the two modes do not disturb each other. Idle gaps carrying junk inputs, and restarts both with and without a symbol in the same cycle, confirm the hold and reload behaviour.

// File: rtl/sym_scrambler.sv
module sym_scrambler #(
  parameter int          GEN_W   = 12,
  parameter logic [11:0] SEED    = 12'hBAD,
  parameter logic [11:0] TAPS    = 12'h052,
  parameter int          STEPS   = 8,
  parameter int          PERIOD  = 160,
  parameter int          PRE_LEN = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       in_valid,
  input  logic       preamble_mode,
  input  logic [2:0] in_sym,
  output logic       out_valid,
  output logic [2:0] out_sym
);
  localparam int CNT_W = $clog2(PERIOD + 1);
  localparam int IDX_W = $clog2(PRE_LEN);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PERIOD);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(PRE_LEN - 1);

  function automatic logic [GEN_W-1:0] advance(input logic [GEN_W-1:0] s);
    logic [GEN_W-1:0] r;
    r = s;
    for (int k = 0; k < STEPS; k++) begin
      if (r[GEN_W-1]) r = {r[GEN_W-2:0], 1'b0} ^ TAPS[GEN_W-1:0];
      else            r = {r[GEN_W-2:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [2:0] pre_key(input logic [IDX_W-1:0] i);
    case (5'(i))
      5'd0: return 3'd7;  5'd1: return 3'd4;  5'd2: return 3'd3;  5'd3: return 3'd0;
      5'd4: return 3'd5;  5'd5: return 3'd1;  5'd6: return 3'd5;  5'd7: return 3'd0;
      5'd8: return 3'd2;  5'd9: return 3'd2;  5'd10: return 3'd1; 5'd11: return 3'd1;
      5'd12: return 3'd5; 5'd13: return 3'd7; 5'd14: return 3'd4; 5'd15: return 3'd3;
      5'd16: return 3'd5; 5'd17: return 3'd0; 5'd18: return 3'd2; 5'd19: return 3'd6;
      5'd20: return 3'd2; 5'd21: return 3'd1; 5'd22: return 3'd6; 5'd23: return 3'd2;
      5'd24: return 3'd0; 5'd25: return 3'd0; 5'd26: return 3'd5; 5'd27: return 3'd0;
      5'd28: return 3'd5; 5'd29: return 3'd2; 5'd30: return 3'd6; default: return 3'd6;
    endcase
  endfunction

  logic [GEN_W-1:0] gen, gen_eff;
  logic [CNT_W-1:0] cnt, cnt_eff;
  logic [IDX_W-1:0] idx, idx_eff;
  logic [2:0]       key;

  assign gen_eff = (restart || cnt == CNT_END) ? SEED[GEN_W-1:0] : gen;
  assign cnt_eff = (restart || cnt == CNT_END) ? '0 : cnt;
  assign idx_eff = restart ? '0 : idx;
  assign key     = preamble_mode ? pre_key(idx_eff) : gen_eff[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen       <= SEED[GEN_W-1:0];
      cnt       <= '0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_sym   <= '0;
    end else begin
      out_valid <= in_valid;
      gen <= gen_eff;
      cnt <= cnt_eff;
      idx <= idx_eff;
      if (in_valid) begin
        out_sym <= in_sym + key;
        if (preamble_mode) begin
          idx <= (idx_eff == IDX_END) ? '0 : idx_eff + 1'b1;
        end else begin
          gen <= advance(gen_eff);
          cnt <= cnt_eff + 1'b1;
        end
      end
    end
  end

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R6
  pre_keeps_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && preamble_mode && !restart && cnt != CNT_END) |=> ($stable(gen) && $stable(cnt)));
  // R6
  data_keeps_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !preamble_mode && !restart) |=> $stable(idx));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !restart) |=> ($stable(out_sym) && $stable(idx)));
  // R7
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !in_valid) |=> (gen == SEED[GEN_W-1:0] && cnt == '0 && idx == '0));
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !preamble_mode && cnt == CNT_END && !restart) |=> cnt == CNT_W'(1));
endmodule

// File: tb/sym_scrambler_bench.sv
module sym_scrambler_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, in_valid = 1'b0, preamble_mode = 1'b0;
  logic [2:0] in_sym = '0;
  logic       out_valid;
  logic [2:0] out_sym;

  int errors = 0, checks = 0;
  int m_gen = 'hBAD, m_cnt = 0, m_idx = 0, last_out = 0;
  int ptab [32] = '{7,4,3,0,5,1,5,0,2,2,1,1,5,7,4,3,5,0,2,6,2,1,6,2,0,0,5,0,5,2,6,6};

  sym_scrambler u_sym_scrambler (.clk(clk), .rst_n(rst_n), .restart(restart),
    .in_valid(in_valid), .preamble_mode(preamble_mode), .in_sym(in_sym),
    .out_valid(out_valid), .out_sym(out_sym));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int step8(int s);
    int v = s;
    for (int k = 0; k < 8; k++) begin
      int top = (v >> 11) & 1;
      v = (v << 1) & 'hFFF;
      if (top != 0) v = v ^ 'h052;
    end
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(string tag, bit v, bit pm, bit rs, int sym);
    int exp = last_out;
    string t = tag;
    @(negedge clk);
    in_valid = v; preamble_mode = pm; restart = rs; in_sym = 3'(sym);
    if (rs) begin m_gen = 'hBAD; m_cnt = 0; m_idx = 0; end
    if (v) begin
      if (pm) begin
        exp = (sym + ptab[m_idx]) % 8;
        m_idx = (m_idx + 1) % 32;
      end else begin
        if (m_cnt == 160) begin m_gen = 'hBAD; m_cnt = 0; t = "R4"; end
        exp = (sym + (m_gen & 7)) % 8;
        m_gen = step8(m_gen);
        m_cnt++;
      end
      last_out = exp;
    end
    @(posedge clk); #1;
    check("R8", int'(out_valid), int'(v));
    check(t, int'(out_sym), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_sym), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 10; i++) send("R2", 1, 0, 0, 0);
    for (int i = 0; i < 340; i++) begin
      if (i % 11 == 5) send("R9", 0, i[0], 0, 7 - (i % 8));
      send("R3", 1, 0, 0, i % 8);
    end
    for (int i = 0; i < 70; i++) send("R5", 1, 1, 0, (i * 3) % 8);
    for (int i = 0; i < 20; i++) send("R6", 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) send("R6", 1, 1, 0, 1);
    for (int i = 0; i < 5; i++) send("R6", 1, 0, 0, 6);
    send("R7", 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) send("R7", 1, 0, 0, i);
    send("R7", 1, 0, 1, 2);
    send("R7", 1, 0, 0, 2);
    for (int i = 0; i < 3; i++) send("R5", 1, 1, 0, 0);
    send("R7", 1, 1, 1, 0);
    send("R7", 1, 1, 0, 0);
    for (int i = 0; i < 6; i++) send("R8", i % 2, 0, 0, 4);
    send("R9", 0, 1, 0, 3);
    send("R9", 1, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule